// File: doc/BRIEF.md
# Serial Configuration Bitstream Memory

This block models a one-bit-wide memory that streams an FPGA configuration bitstream out one bit per clock. A loading FPGA supplies the clock, drives an active-low chip enable from its "configuration done" signal, and drives a combined reset/output-enable input from its "init" signal. While both enables are active, each rising clock edge moves an internal bit address forward by one. The bit at the current address is presented on a data output. An output-enable flag takes the place of a tri-state pin.

The reset/output-enable input has a polarity chosen by a parameter. While it is in its reset sense, the address goes back to zero and the output is released. A high chip enable also releases the output, clears the address and raises a standby flag. When the address reaches the last location, it stays there and does not wrap. The storage depth is a parameter; a typical large part holds 781,216 bits. A simple synchronous write port loads the storage before it is read.

Top module: `cfg_bitstream_mem`

## Requirements
- R1: Parameter `RST_ACT_HIGH` sets the polarity of `rst_oe`. With 1 (the default), `rst_oe`=1 is the reset sense. With 0, `rst_oe`=0 is the reset sense.
- R2: While `rst_oe` is in its reset sense and `ce_n`=0, `dout_en`=0 and `dout`=0. Every rising edge in this state loads address 0.
- R3: While `ce_n`=1, `standby`=1, `dout_en`=0 and `dout`=0, and every rising edge loads address 0, whatever the value of `rst_oe`.
- R4: When `ce_n`=0 and `rst_oe` is not in its reset sense, each rising edge advances the address by exactly one.
- R5: At address DEPTH-1 the address holds on further enabled edges and never wraps to 0.
- R6: When the last clearing condition is released, `dout` shows storage bit 0 with `dout_en`=1 before the next rising edge. This assumes the clearing condition was present for at least one edge.
- R7: After each rising edge, and with no further edge, `dout` equals the stored bit at the new address while `dout_en`=1.
- R8: `wr_en`=1 stores `wr_data` at `wr_addr` on the rising edge. A write has no effect on the read address, and a later read of that location returns the new bit.
- R9: `rst_n`=0 clears the address at once, without a clock. After `rst_n` rises, the address stays at 0 through the next two rising edges.
- R10: `standby` equals `ce_n` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the loading device |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset/output enable, polarity set by RST_ACT_HIGH |
| wr_en | input | 1 | Storage write strobe |
| wr_addr | input | AW | Storage write address |
| wr_data | input | 1 | Storage write bit |
| dout | output | 1 | Serial data bit, 0 when not driven |
| dout_en | output | 1 | High when the data pin would be driven |
| standby | output | 1 | High while the chip enable is inactive |

## Verification
The storage is filled with an irregular bit pattern. A long run of 1s or 0s cannot hide an address that skips or repeats, because neighbouring bits in the pattern differ often. The stream is interrupted in several ways: by reset/output-enable alone, by chip enable alone, by the asynchronous reset, and by both enables together. Each interruption must restart the stream from bit 0, and the order of outputs separates an address that clears from one that only pauses. Two instances with opposite polarity receive the same and the opposite `rst_oe` levels, which exposes an inverted polarity decode. A run past the last address, with a write to that address, separates holding from wrapping and shows that the output follows new storage contents without moving the address.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  typedef enum logic [1:0] {
    RD_STANDBY = 2'd0,
    RD_CLEAR   = 2'd1,
    RD_STREAM  = 2'd2
  } rd_mode_e;

  function automatic rd_mode_e decode_mode(input logic ce_n_i, input logic rst_sense_i);
    if (ce_n_i)           return RD_STANDBY;
    else if (rst_sense_i) return RD_CLEAR;
    else                  return RD_STREAM;
  endfunction
endpackage

// File: rtl/cfgmem_rst_sync.sv
module cfgmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cfgmem_addr_ctr.sv
module cfgmem_addr_ctr #(
  parameter int DEPTH = 1000,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          at_last;
  logic          addr_ce;

  always_comb begin
    at_last = (addr_q == LAST);
    addr_ce = clr || !at_last;
    if (clr) addr_d = '0;
    else     addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ce) addr_q <= addr_d;
  end

  assign addr = addr_q;

  assert_clear_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr_q == '0));

  assert_hold_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && addr_q == LAST) |=> (addr_q == LAST));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && addr_q != LAST) |=> (addr_q == $past(addr_q) + AW'(1)));

  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST);
endmodule

// File: rtl/cfgmem_bit_store.sv
module cfgmem_bit_store #(
  parameter int DEPTH = 1000,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_data
);
  logic [DEPTH-1:0] bits_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (cell_we) bits_q[g] <= wr_data;
    end
  end

  assign rd_data = bits_q[rd_addr];
endmodule

// File: rtl/cfg_bitstream_mem.sv
module cfg_bitstream_mem
  import cfgmem_pkg::*;
#(
  parameter int DEPTH        = 1000,
  parameter bit RST_ACT_HIGH = 1'b1,
  parameter int AW           = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  output logic          dout,
  output logic          dout_en,
  output logic          standby
);
  logic     rst_n_sync;
  logic     rst_sense;
  rd_mode_e mode;
  logic     ctr_clr;
  logic [AW-1:0] rd_addr;
  logic     rd_bit;

  cfgmem_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  generate
    if (RST_ACT_HIGH) begin : g_pol_high
      assign rst_sense = rst_oe;
    end else begin : g_pol_low
      assign rst_sense = !rst_oe;
    end
  endgenerate

  always_comb begin
    mode    = decode_mode(ce_n, rst_sense);
    ctr_clr = (mode != RD_STREAM);
  end

  cfgmem_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (ctr_clr),
    .addr  (rd_addr)
  );

  cfgmem_bit_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_bit)
  );

  always_comb begin
    dout_en = (mode == RD_STREAM);
    dout    = dout_en & rd_bit;
    standby = (mode == RD_STANDBY);
  end

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (standby && !dout_en && !dout));

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && rst_sense) |-> (!dout_en && !dout && !standby));

  assert_standby_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby == ce_n);

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> (rd_addr == '0));
endmodule

// File: tb/cfg_bitstream_mem_tb.sv
module cfg_bitstream_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 37;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, ce_n, roe_hi, roe_lo, wr_en, wr_data;
  logic [AW-1:0] wr_addr;
  logic dout_h, den_h, sb_h, dout_l, den_l, sb_l;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  bit mm[DEPTH];
  int ma_h = 0, ma_l = 0, hold = 2;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bitstream_mem #(.DEPTH(DEPTH), .RST_ACT_HIGH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(roe_hi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_h), .dout_en(den_h), .standby(sb_h));

  cfg_bitstream_mem #(.DEPTH(DEPTH), .RST_ACT_HIGH(1'b0)) u_dut_lo (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(roe_lo),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_l), .dout_en(den_l), .standby(sb_l));

  // Reference model: storage, one address per instance, two-edge hold after rst_n
  always @(posedge clk) begin
    if (!rst_n) begin
      hold = 2; ma_h = 0; ma_l = 0;
    end else if (hold > 0) begin
      hold = hold - 1; ma_h = 0; ma_l = 0;
    end else begin
      if (ce_n || roe_hi) ma_h = 0; else if (ma_h < DEPTH-1) ma_h = ma_h + 1;
      if (ce_n || !roe_lo) ma_l = 0; else if (ma_l < DEPTH-1) ma_l = ma_l + 1;
    end
    if (wr_en && int'(wr_addr) < DEPTH) mm[int'(wr_addr)] = wr_data;
  end

  always @(negedge rst_n) begin
    ma_h = 0; ma_l = 0;
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    logic eo_h, eo_l;
    string th, tl;
    cycles++;
    eo_h = !ce_n && !roe_hi;
    eo_l = !ce_n && roe_lo;
    th = ce_n ? "R3" : (roe_hi ? "R2" : "R7");
    tl = ce_n ? "R3" : (!roe_lo ? "R1" : "R7");
    check(th, den_h, eo_h, "hi dout_en");
    check(th, dout_h, eo_h & mm[ma_h], "hi dout");
    check("R10", sb_h, ce_n, "hi standby");
    check(tl, den_l, eo_l, "lo dout_en");
    check(tl, dout_l, eo_l & mm[ma_l], "lo dout");
    check("R10", sb_l, ce_n, "lo standby");
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; roe_hi = 1'b1; roe_lo = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = 1'b0;
    step(2);
    #1;
    check("R3", sb_h, 1'b1, "reset-state standby");
    check("R3", den_h, 1'b0, "reset-state dout_en");
    // R8: preload an irregular pattern while in standby
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = ((i * 7 + 3) % 5) < 2;
      step(1);
    end
    wr_en = 1'b0;
    rst_n = 1'b1;
    step(3);
    // R2: chip enabled but reset/output-enable in reset sense
    ce_n = 1'b0;
    step(2);
    check("R2", den_h, 1'b0, "held reset dout_en");
    // R6: release, bit 0 visible before next edge
    roe_hi = 1'b0; roe_lo = 1'b1;
    #1;
    check("R6", den_h, 1'b1, "first bit enable");
    check("R6", dout_h, mm[0], "first bit value");
    step(10);
    // R4/R7: stream position after 10 edges
    #1;
    check("R4", dout_h, mm[10], "bit after ten edges");
    // R2: reset pulse mid-stream
    roe_hi = 1'b1; roe_lo = 1'b0;
    step(1);
    roe_hi = 1'b0; roe_lo = 1'b1;
    #1;
    check("R2", dout_h, mm[0], "restart after reset pulse");
    step(5);
    // R3: chip enable off with reset/output-enable inactive
    ce_n = 1'b1;
    step(2);
    check("R3", sb_l, 1'b1, "standby while streaming inputs active");
    ce_n = 1'b0;
    #1;
    check("R3", dout_l, mm[0], "restart after standby");
    // R5: run past the last address
    step(DEPTH + 8);
    #1;
    check("R5", dout_h, mm[DEPTH-1], "hold at last address");
    check("R5", den_h, 1'b1, "still enabled at last address");
    // R8: write the location being read, address unmoved
    wr_en = 1'b1; wr_addr = AW'(DEPTH-1); wr_data = ~mm[DEPTH-1];
    step(1);
    wr_en = 1'b0;
    #1;
    check("R8", dout_h, ~((((DEPTH-1) * 7 + 3) % 5) < 2), "new bit at held address");
    step(2);
    // R1: same level on both polarities
    roe_hi = 1'b1; roe_lo = 1'b1;
    step(2);
    check("R1", den_h, 1'b0, "active-high instance in reset");
    check("R1", den_l, 1'b1, "active-low instance streaming");
    roe_hi = 1'b0;
    step(4);
    // R9: asynchronous block reset mid-stream
    rst_n = 1'b0;
    #1;
    check("R9", dout_h, mm[0], "async clear to bit 0");
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R9", dout_h, mm[0], "held through two edges");
    step(3);
    check("R9", dout_h, mm[3], "counting resumes");
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule